// File: doc/BRIEF.md
# AXI4 SRAM Bridge with Capability Tags

The block is an AXI4 subordinate that fronts an on-chip SRAM. It accepts single-beat and INCR burst read and write requests from the system crossbar and turns each beat into one access on a plain single-port RAM interface. The RAM interface has a request, a write enable, a word index, write data, a byte mask and registered read data. The storage array is a behavioural memory held inside the block. The data path is 64 bits wide.

Next to the data, the block keeps one capability tag bit for every 16-byte aligned region. A tag arrives with write data on `wuser` and leaves with read data on `ruser`. Two 64-bit beats make up one region. A tag can only be set by one burst that writes the lower half and then the upper half of a region, with every byte enabled and `wuser` high on both beats. Any other write that touches the region clears its tag. A read returns the region's tag on both of its beats, and one burst may cross tagged and untagged regions.

The block serves one transaction at a time. A write request wins over a read request offered in the same cycle. A request that is not a plain INCR burst of 8-byte beats at an 8-byte aligned address is answered with SLVERR and leaves memory and tags as they were.

Top module: `axi_cap_sram`

## Requirements
- R1: A write burst stores each beat at consecutive 8-byte words, changing only the bytes whose `wstrb` bit is set. A read burst returns the stored words in order from the start address. INCR is `awburst`/`arburst` = 2'b01 and the beat size code is 3.
- R2: `bid` and `rid` equal the ID of the request being answered.
- R3: A read burst returns exactly `arlen`+1 beats with `rlast` high on the final beat only. A write burst takes exactly `awlen`+1 data beats, and `wlast` is expected on the last of them.
- R4: A region's tag becomes 1 only when one burst writes its lower word (address bit 3 = 0) and then its upper word (bit 3 = 1) in consecutive beats, both with `wstrb` = 8'hFF and `wuser` = 1.
- R5: Every other successful write beat that touches a region clears its tag. This covers a single beat with full strobes, a partial strobe, `wuser` = 0, and a burst that starts on an upper word.
- R6: Each read beat returns the tag of its region on `ruser`, so both beats of a region carry the same value, and a burst may mix tagged and untagged regions.
- R7: When `awvalid` and `arvalid` are both high while idle, `awready` is 1 and `arready` is 0. The read is accepted only after the write response completes.
- R8: A request with a burst type other than INCR, a size other than 3, or address bits [2:0] not zero gets response 2'b10 (SLVERR). A write still consumes its beats but changes no data or tag. A read returns `arlen`+1 beats of zero data with `ruser` = 0 and `rlast` on the last beat. A good request gets 2'b00.
- R9: While `rvalid` or `bvalid` is high and its ready is low, the valid stays high and the payload stays unchanged, and no read beat is lost.
- R10: After reset, `bvalid` and `rvalid` are 0, `awready` and `arready` are 1, and all tags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| awid | input | ID_W | Write request ID |
| awaddr | input | ADDR_W | Write start byte address |
| awlen | input | 8 | Write beats minus one |
| awsize | input | 3 | Write beat size code |
| awburst | input | 2 | Write burst type |
| awvalid | input | 1 | Write request valid |
| awready | output | 1 | Write request accepted |
| wdata | input | 64 | Write data |
| wstrb | input | 8 | Write byte enables |
| wlast | input | 1 | Final write beat |
| wuser | input | 1 | Capability tag of the beat |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data accepted |
| bid | output | ID_W | Write response ID |
| bresp | output | 2 | Write response code |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response taken |
| arid | input | ID_W | Read request ID |
| araddr | input | ADDR_W | Read start byte address |
| arlen | input | 8 | Read beats minus one |
| arsize | input | 3 | Read beat size code |
| arburst | input | 2 | Read burst type |
| arvalid | input | 1 | Read request valid |
| arready | output | 1 | Read request accepted |
| rid | output | ID_W | Read response ID |
| rdata | output | 64 | Read data |
| rresp | output | 2 | Read response code |
| rlast | output | 1 | Final read beat |
| ruser | output | 1 | Capability tag of the beat's region |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data taken |

## Verification
Properties checked on every cycle cover the response handshakes: read and write payloads hold steady under backpressure, only one request handshake happens per cycle, the channel goes quiet after a final read beat, `wlast` lines up with the counted last beat, and a tag is never written as 1 except on a full-strobe upper word. How tags come out of a given sequence of strobes, tag bits and burst start positions can only be shown by the bench. The same holds for error requests leaving memory untouched and for read data matching earlier writes. The bench sweeps every combination of strobe fullness and tag bit over the two halves of a region and then reads each result back.

// File: rtl/tsram_pkg.sv
// Shared types and constants for the tagged AXI4 SRAM bridge.
// Assumes a 64-bit data path; one tag covers two consecutive words.
package tsram_pkg;
    localparam int DATA_W = 64;
    localparam int STRB_W = DATA_W / 8;

    typedef enum logic [1:0] {
        BURST_FIXED = 2'b00,
        BURST_INCR  = 2'b01,
        BURST_WRAP  = 2'b10,
        BURST_RSVD  = 2'b11
    } burst_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;
    localparam logic [2:0] BEAT_SIZE   = 3'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WDATA,
        ST_WRESP,
        ST_RISSUE,
        ST_RWAIT,
        ST_RSEND
    } state_e;

    // A request is refused unless it is an aligned INCR burst of full words.
    function automatic logic req_bad(input logic [1:0] burst,
                                     input logic [2:0] size,
                                     input logic [2:0] low_addr);
        return (burst != BURST_INCR) || (size != BEAT_SIZE) || (low_addr != 3'd0);
    endfunction
endpackage

// File: rtl/tsram_store.sv
// Behavioural single-port word memory with a side array of region tags.
// One access per cycle; read data and tag appear one cycle after the request.
// Tags reset to zero; data words are not reset.
module tsram_store import tsram_pkg::*; #(
    parameter int WORD_AW = 9,
    localparam int WORDS  = 1 << WORD_AW,
    localparam int TAGS   = WORDS / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 we,
    input  logic [WORD_AW-1:0]   idx,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [STRB_W-1:0]    wstrb,
    input  logic                 tag_wval,
    output logic [DATA_W-1:0]    rdata,
    output logic                 rtag
);
    logic [DATA_W-1:0] mem [WORDS];
    logic [TAGS-1:0]   tags;

    // Byte-masked data write and registered data read.
    always_ff @(posedge clk) begin
        if (req && we) begin
            for (int b = 0; b < STRB_W; b++) begin
                if (wstrb[b]) mem[idx][b*8 +: 8] <= wdata[b*8 +: 8];
            end
        end else if (req) begin
            rdata <= mem[idx];
        end
    end

    // Tag array: cleared by reset, rewritten on every write, read with the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tags <= '0;
            rtag <= 1'b0;
        end else if (req && we) begin
            tags[idx[WORD_AW-1:1]] <= tag_wval;
        end else if (req) begin
            rtag <= tags[idx[WORD_AW-1:1]];
        end
    end

    // R4: a tag is only ever written as 1 by a full-strobe upper-word beat.
    a_r4_set_needs_full_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && tag_wval) |-> (wstrb == '1 && idx[0]));
endmodule

// File: rtl/tsram_tagger.sv
// Decides the tag value written with each data beat.
// Remembers whether the previous beat of the same burst was a full, tagged lower
// word; the upper word then sets the tag only if it too is full and tagged.
module tsram_tagger (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic first,
    input  logic upper,
    input  logic full,
    input  logic user,
    output logic tag_wval
);
    logic low_ok_q;

    // Track a qualifying lower half; any upper beat consumes the mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_ok_q <= 1'b0;
        end else if (fire) begin
            low_ok_q <= !upper && full && user;
        end
    end

    // Lower beats always clear; upper beats set only after a qualifying lower beat.
    always_comb begin
        tag_wval = upper && !first && low_ok_q && full && user;
    end
endmodule

// File: rtl/tsram_ctrl.sv
// AXI4 transaction sequencer: one request at a time, writes before reads.
// Writes: one RAM write per accepted beat, then one response.
// Reads: issue, wait one cycle for RAM data, hold the beat until taken.
// Assumes the manager drives wlast on the beat numbered awlen.
module tsram_ctrl import tsram_pkg::*; #(
    parameter int ADDR_W  = 12,
    parameter int ID_W    = 4,
    localparam int WORD_AW = ADDR_W - 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ID_W-1:0]     awid,
    input  logic [ADDR_W-1:0]   awaddr,
    input  logic [7:0]          awlen,
    input  logic [2:0]          awsize,
    input  logic [1:0]          awburst,
    input  logic                awvalid,
    output logic                awready,
    input  logic                wlast,
    input  logic                wvalid,
    output logic                wready,
    output logic [ID_W-1:0]     bid,
    output logic [1:0]          bresp,
    output logic                bvalid,
    input  logic                bready,
    input  logic [ID_W-1:0]     arid,
    input  logic [ADDR_W-1:0]   araddr,
    input  logic [7:0]          arlen,
    input  logic [2:0]          arsize,
    input  logic [1:0]          arburst,
    input  logic                arvalid,
    output logic                arready,
    output logic [ID_W-1:0]     rid,
    output logic [DATA_W-1:0]   rdata,
    output logic [1:0]          rresp,
    output logic                rlast,
    output logic                ruser,
    output logic                rvalid,
    input  logic                rready,
    output logic                ram_req,
    output logic                ram_we,
    output logic [WORD_AW-1:0]  ram_idx,
    input  logic [DATA_W-1:0]   ram_rdata,
    input  logic                ram_rtag,
    output logic                beat_fire,
    output logic                beat_first
);
    state_e             state_q;
    logic [ID_W-1:0]    id_q;
    logic [WORD_AW-1:0] widx_q;
    logic [7:0]         len_q;
    logic [7:0]         cnt_q;
    logic               err_q;
    logic               first_q;
    logic [DATA_W-1:0]  rdata_q;
    logic               ruser_q;
    logic               at_last;

    assign at_last = (cnt_q == len_q);

    // Handshake and RAM strobes decoded from the current state.
    always_comb begin
        awready   = 1'b0;
        arready   = 1'b0;
        wready    = 1'b0;
        bvalid    = 1'b0;
        rvalid    = 1'b0;
        ram_req   = 1'b0;
        ram_we    = 1'b0;
        beat_fire = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                awready = 1'b1;
                arready = !awvalid;
            end
            ST_WDATA: begin
                wready = 1'b1;
                if (wvalid && !err_q) begin
                    ram_req   = 1'b1;
                    ram_we    = 1'b1;
                    beat_fire = 1'b1;
                end
            end
            ST_WRESP:  bvalid  = 1'b1;
            ST_RISSUE: ram_req = !err_q;
            ST_RSEND:  rvalid  = 1'b1;
            default: ;
        endcase
    end

    // Response payloads come straight from the held transaction state.
    always_comb begin
        ram_idx    = widx_q;
        beat_first = first_q;
        bid        = id_q;
        rid        = id_q;
        bresp      = err_q ? RESP_SLVERR : RESP_OKAY;
        rresp      = err_q ? RESP_SLVERR : RESP_OKAY;
        rdata      = rdata_q;
        ruser      = ruser_q;
        rlast      = (state_q == ST_RSEND) && at_last;
    end

    // Transaction sequencing, address stepping and read-beat holding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            id_q    <= '0;
            widx_q  <= '0;
            len_q   <= '0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
            first_q <= 1'b0;
            rdata_q <= '0;
            ruser_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (awvalid) begin
                        id_q    <= awid;
                        widx_q  <= awaddr[ADDR_W-1:3];
                        len_q   <= awlen;
                        cnt_q   <= '0;
                        err_q   <= req_bad(awburst, awsize, awaddr[2:0]);
                        first_q <= 1'b1;
                        state_q <= ST_WDATA;
                    end else if (arvalid) begin
                        id_q    <= arid;
                        widx_q  <= araddr[ADDR_W-1:3];
                        len_q   <= arlen;
                        cnt_q   <= '0;
                        err_q   <= req_bad(arburst, arsize, araddr[2:0]);
                        state_q <= ST_RISSUE;
                    end
                end
                ST_WDATA: begin
                    if (wvalid) begin
                        widx_q  <= widx_q + 1'b1;
                        cnt_q   <= cnt_q + 8'd1;
                        first_q <= 1'b0;
                        if (at_last) state_q <= ST_WRESP;
                    end
                end
                ST_WRESP: begin
                    if (bready) state_q <= ST_IDLE;
                end
                ST_RISSUE: state_q <= ST_RWAIT;
                ST_RWAIT: begin
                    rdata_q <= err_q ? '0 : ram_rdata;
                    ruser_q <= err_q ? 1'b0 : ram_rtag;
                    state_q <= ST_RSEND;
                end
                ST_RSEND: begin
                    if (rready) begin
                        if (at_last) begin
                            state_q <= ST_IDLE;
                        end else begin
                            cnt_q   <= cnt_q + 8'd1;
                            widx_q  <= widx_q + 1'b1;
                            state_q <= ST_RISSUE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R7: never two request handshakes in one cycle.
    a_r7_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({awvalid && awready, arvalid && arready}));

    // R9: a stalled read beat keeps its payload.
    a_r9_r_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(ruser)
                                 && $stable(rlast) && $stable(rid) && $stable(rresp)));

    // R9: a stalled write response keeps its payload.
    a_r9_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> (bvalid && $stable(bid) && $stable(bresp)));

    // R3: after the final read beat is taken the channel goes quiet.
    a_r3_quiet_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && rready && rlast) |=> !rvalid);

    // R3: the manager's wlast agrees with the counted last beat.
    a_r3_wlast_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        (wvalid && wready) |-> (wlast == at_last));
endmodule

// File: rtl/axi_cap_sram.sv
// Top of the tagged AXI4 SRAM bridge: sequencer, tag decision and storage.
// One transaction in flight; memory size is 2**ADDR_W bytes.
module axi_cap_sram import tsram_pkg::*; #(
    parameter int ADDR_W = 12,
    parameter int ID_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ID_W-1:0]     awid,
    input  logic [ADDR_W-1:0]   awaddr,
    input  logic [7:0]          awlen,
    input  logic [2:0]          awsize,
    input  logic [1:0]          awburst,
    input  logic                awvalid,
    output logic                awready,
    input  logic [63:0]         wdata,
    input  logic [7:0]          wstrb,
    input  logic                wlast,
    input  logic                wuser,
    input  logic                wvalid,
    output logic                wready,
    output logic [ID_W-1:0]     bid,
    output logic [1:0]          bresp,
    output logic                bvalid,
    input  logic                bready,
    input  logic [ID_W-1:0]     arid,
    input  logic [ADDR_W-1:0]   araddr,
    input  logic [7:0]          arlen,
    input  logic [2:0]          arsize,
    input  logic [1:0]          arburst,
    input  logic                arvalid,
    output logic                arready,
    output logic [ID_W-1:0]     rid,
    output logic [63:0]         rdata,
    output logic [1:0]          rresp,
    output logic                rlast,
    output logic                ruser,
    output logic                rvalid,
    input  logic                rready
);
    localparam int WORD_AW = ADDR_W - 3;

    logic               ram_req;
    logic               ram_we;
    logic [WORD_AW-1:0] ram_idx;
    logic [DATA_W-1:0]  ram_rdata;
    logic               ram_rtag;
    logic               beat_fire;
    logic               beat_first;
    logic               tag_wval;

    tsram_ctrl #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .awid(awid), .awaddr(awaddr), .awlen(awlen), .awsize(awsize),
        .awburst(awburst), .awvalid(awvalid), .awready(awready),
        .wlast(wlast), .wvalid(wvalid), .wready(wready),
        .bid(bid), .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .arid(arid), .araddr(araddr), .arlen(arlen), .arsize(arsize),
        .arburst(arburst), .arvalid(arvalid), .arready(arready),
        .rid(rid), .rdata(rdata), .rresp(rresp), .rlast(rlast),
        .ruser(ruser), .rvalid(rvalid), .rready(rready),
        .ram_req(ram_req), .ram_we(ram_we), .ram_idx(ram_idx),
        .ram_rdata(ram_rdata), .ram_rtag(ram_rtag),
        .beat_fire(beat_fire), .beat_first(beat_first)
    );

    tsram_tagger u_tagger (
        .clk(clk), .rst_n(rst_n),
        .fire(beat_fire), .first(beat_first), .upper(ram_idx[0]),
        .full(wstrb == '1), .user(wuser), .tag_wval(tag_wval)
    );

    tsram_store #(.WORD_AW(WORD_AW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .req(ram_req), .we(ram_we), .idx(ram_idx),
        .wdata(wdata), .wstrb(wstrb), .tag_wval(tag_wval),
        .rdata(ram_rdata), .rtag(ram_rtag)
    );
endmodule

// File: tb/tb_axi_cap_sram.sv
`timescale 1ns/1ps
module tb_axi_cap_sram;
    localparam int WORDS = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0]  awid = '0;  logic [11:0] awaddr = '0; logic [7:0] awlen = '0;
    logic [2:0]  awsize = 3'd3; logic [1:0] awburst = 2'b01; logic awvalid = 1'b0;
    logic awready;
    logic [63:0] wdata = '0; logic [7:0] wstrb = '0; logic wlast = 1'b0;
    logic wuser = 1'b0; logic wvalid = 1'b0; logic wready;
    logic [3:0] bid; logic [1:0] bresp; logic bvalid; logic bready = 1'b0;
    logic [3:0]  arid = '0;  logic [11:0] araddr = '0; logic [7:0] arlen = '0;
    logic [2:0]  arsize = 3'd3; logic [1:0] arburst = 2'b01; logic arvalid = 1'b0;
    logic arready;
    logic [3:0] rid; logic [63:0] rdata; logic [1:0] rresp;
    logic rlast, ruser, rvalid; logic rready = 1'b0;

    axi_cap_sram dut (.*);

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] mdl_mem [WORDS];
    logic        mdl_tag [WORDS/2];
    logic [63:0] g_data [32];
    logic [7:0]  g_strb [32];
    logic        g_user [32];

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic is_bad(input logic [1:0] burst, input logic [2:0] size,
                                    input logic [11:0] addr);
        return burst != 2'b01 || size != 3'd3 || addr[2:0] != 3'd0;
    endfunction

    // Model: apply strobes; tag set only by full, tagged lower then upper in one burst.
    task automatic mdl_write(input int word0, input int len);
        logic low_ok = 1'b0;
        for (int i = 0; i <= len; i++) begin
            int w = (word0 + i) % WORDS;
            logic full = (g_strb[i] == 8'hFF);
            for (int b = 0; b < 8; b++)
                if (g_strb[i][b]) mdl_mem[w][b*8 +: 8] = g_data[i][b*8 +: 8];
            if (w % 2 == 0) begin
                mdl_tag[w/2] = 1'b0;
                low_ok = full && g_user[i];
            end else begin
                mdl_tag[w/2] = (i > 0) && low_ok && full && g_user[i];
                low_ok = 1'b0;
            end
        end
    endtask

    task automatic aw_set(input logic [3:0] id, input logic [11:0] addr, input logic [7:0] len,
                          input logic [1:0] burst, input logic [2:0] size);
        awid = id; awaddr = addr; awlen = len; awburst = burst; awsize = size; awvalid = 1'b1;
    endtask

    task automatic aw_wait();
        while (!awready) @(negedge clk);
        @(negedge clk);
        awvalid = 1'b0;
    endtask

    task automatic w_send(input int len);
        for (int i = 0; i <= len; i++) begin
            wvalid = 1'b1; wdata = g_data[i]; wstrb = g_strb[i]; wuser = g_user[i];
            wlast = (i == len);
            while (!wready) @(negedge clk);
            @(negedge clk);
        end
        wvalid = 1'b0; wlast = 1'b0;
    endtask

    task automatic b_take(input logic [3:0] id, input logic [1:0] exp_resp, input bit stall);
        while (!bvalid) @(negedge clk);
        if (stall) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(bvalid === 1'b1 && bid === id, "R9 bvalid held", {59'd0, bvalid, bid}, {59'd1, id});
            end
        end
        chk(bid === id, "R2 bid", bid, id);
        chk(bresp === exp_resp, "R8 bresp", bresp, exp_resp);
        bready = 1'b1;
        @(negedge clk);
        bready = 1'b0;
    endtask

    task automatic wr(input logic [3:0] id, input int word0, input int len,
                      input logic [1:0] burst, input logic [2:0] size, input int lowbits,
                      input bit bstall);
        logic [11:0] a = 12'(word0 * 8 + lowbits);
        logic bad = is_bad(burst, size, a);
        aw_set(id, a, 8'(len), burst, size);
        aw_wait();
        w_send(len);
        b_take(id, bad ? 2'b10 : 2'b00, bstall);
        if (!bad) mdl_write(word0, len);
    endtask

    task automatic ar_set(input logic [3:0] id, input logic [11:0] addr, input logic [7:0] len,
                          input logic [1:0] burst, input logic [2:0] size);
        arid = id; araddr = addr; arlen = len; arburst = burst; arsize = size; arvalid = 1'b1;
    endtask

    task automatic r_take(input logic [3:0] id, input int word0, input int len,
                          input bit bad, input bit stall);
        int beat = 0;
        int cyc = 0;
        while (beat <= len) begin
            rready = stall ? (cyc % 3 != 0) : 1'b1;
            cyc++;
            if (rvalid && rready) begin
                int w = (word0 + beat) % WORDS;
                logic [63:0] ed = bad ? 64'd0 : mdl_mem[w];
                logic eu = bad ? 1'b0 : mdl_tag[w/2];
                chk(rid === id, "R2 rid", rid, id);
                chk(rdata === ed, bad ? "R8 error data" : "R1 read data", rdata, ed);
                chk(ruser === eu, "R6 ruser tag", ruser, eu);
                chk(rlast === (beat == len), "R3 rlast", rlast, (beat == len));
                chk(rresp === (bad ? 2'b10 : 2'b00), "R8 rresp", rresp, bad ? 2'b10 : 2'b00);
                beat++;
            end
            @(negedge clk);
        end
        rready = 1'b0;
        chk(rvalid === 1'b0, "R3 no extra beat", rvalid, 0);
    endtask

    task automatic rd(input logic [3:0] id, input int word0, input int len,
                      input logic [1:0] burst, input logic [2:0] size, input int lowbits,
                      input bit stall);
        logic [11:0] a = 12'(word0 * 8 + lowbits);
        ar_set(id, a, 8'(len), burst, size);
        while (!arready) @(negedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        r_take(id, word0, len, is_bad(burst, size, a), stall);
    endtask

    task automatic fill(input int n, input logic [7:0] s, input bit u, input int seed);
        for (int i = 0; i < n; i++) begin
            g_data[i] = {32'(seed * 40503 + i * 977), 32'(i * 65537 + seed)};
            g_strb[i] = s;
            g_user[i] = u;
        end
    endtask

    task automatic run_all();
        for (int t = 0; t < WORDS/2; t++) mdl_tag[t] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle state after reset
        chk(bvalid === 1'b0, "R10 bvalid reset", bvalid, 0);
        chk(rvalid === 1'b0, "R10 rvalid reset", rvalid, 0);
        chk(awready === 1'b1, "R10 awready idle", awready, 1);
        chk(arready === 1'b1, "R10 arready idle", arready, 1);

        // R1: fill words 0..63, then read them back with and without stalls (R9)
        for (int k = 0; k < 4; k++) begin
            fill(16, 8'hFF, 1'b0, k + 1);
            wr(4'(k), k * 16, 15, 2'b01, 3'd3, 0, k == 1);
        end
        rd(4'd5, 0, 31, 2'b01, 3'd3, 0, 1'b0);
        rd(4'd6, 32, 31, 2'b01, 3'd3, 0, 1'b1);
        // R10: tags are zero after reset on a fresh region
        rd(4'd7, 64, 1, 2'b01, 3'd3, 0, 1'b0);

        // R4/R5: every strobe-fullness and tag-bit combination over one region
        for (int c = 0; c < 16; c++) begin
            fill(2, 8'hFF, 1'b0, 100 + c);
            g_strb[0] = c[0] ? 8'hFF : 8'h3C; g_user[0] = c[1];
            g_strb[1] = c[2] ? 8'hFF : 8'hC3; g_user[1] = c[3];
            wr(4'(c), 4 + 2 * c, 1, 2'b01, 3'd3, 0, 1'b0);
            rd(4'(15 - c), 4 + 2 * c, 1, 2'b01, 3'd3, 0, 1'b0);
        end
        // R6: one burst over tagged and untagged regions
        rd(4'd9, 4, 31, 2'b01, 3'd3, 0, 1'b1);

        // R5: burst starting on an upper word clears that region, sets the next
        fill(2, 8'hFF, 1'b1, 200);
        wr(4'd1, 40, 1, 2'b01, 3'd3, 0, 1'b0);
        fill(3, 8'hFF, 1'b1, 201);
        wr(4'd2, 41, 2, 2'b01, 3'd3, 0, 1'b0);
        rd(4'd3, 40, 3, 2'b01, 3'd3, 0, 1'b0);
        // R5: single full tagged beat on upper word clears
        fill(1, 8'hFF, 1'b1, 202);
        wr(4'd4, 43, 0, 2'b01, 3'd3, 0, 1'b0);
        rd(4'd5, 42, 1, 2'b01, 3'd3, 0, 1'b0);
        // R5: single full tagged beat on lower word clears
        fill(2, 8'hFF, 1'b1, 203);
        wr(4'd6, 44, 1, 2'b01, 3'd3, 0, 1'b0);
        fill(1, 8'hFF, 1'b1, 204);
        wr(4'd7, 44, 0, 2'b01, 3'd3, 0, 1'b0);
        rd(4'd8, 44, 1, 2'b01, 3'd3, 0, 1'b0);

        // R3/R2: read lengths 1..8 beats
        for (int l = 0; l < 8; l++) rd(4'(l + 3), 48 + l, l, 2'b01, 3'd3, 0, l[0]);

        // R8: refused requests leave data and tags untouched (region 17 is tagged)
        fill(2, 8'hFF, 1'b1, 300);
        wr(4'd10, 34, 1, 2'b00, 3'd3, 0, 1'b1);
        rd(4'd11, 34, 1, 2'b01, 3'd3, 0, 1'b0);
        fill(2, 8'hFF, 1'b0, 301);
        wr(4'd12, 10, 1, 2'b10, 3'd3, 0, 1'b0);
        wr(4'd13, 10, 1, 2'b01, 3'd2, 0, 1'b0);
        wr(4'd14, 10, 1, 2'b01, 3'd3, 4, 1'b0);
        rd(4'd15, 10, 1, 2'b01, 3'd3, 0, 1'b0);
        rd(4'd1, 8, 3, 2'b10, 3'd3, 0, 1'b1);
        rd(4'd2, 8, 2, 2'b01, 3'd3, 4, 1'b0);
        rd(4'd3, 8, 0, 2'b01, 3'd1, 0, 1'b0);

        // R7: simultaneous requests, write goes first; read sees the new data
        fill(2, 8'hFF, 1'b1, 400);
        aw_set(4'd6, 12'(60 * 8), 8'd1, 2'b01, 3'd3);
        ar_set(4'd9, 12'(60 * 8), 8'd1, 2'b01, 3'd3);
        #1;
        chk(awready === 1'b1, "R7 awready wins", awready, 1);
        chk(arready === 1'b0, "R7 arready held off", arready, 0);
        aw_wait();
        chk(arready === 1'b0, "R7 read waits for write", arready, 0);
        w_send(1);
        b_take(4'd6, 2'b00, 1'b0);
        mdl_write(60, 1);
        while (!arready) @(negedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        r_take(4'd9, 60, 1, 1'b0, 1'b1);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule